// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock plus open-drain data). It gives a host read and write access to a bank of byte-wide configuration registers. It runs entirely in the system clock domain. Both bus lines pass through a synchronizer, and the block finds start conditions, stop conditions and clock edges from the synchronized samples. It never drives the clock line. It pulls the data line low only to acknowledge a byte or to send a 0 bit of read data.

A transaction starts with a 7-bit device address and a direction bit. The 7-bit address is compared against a value the chip supplies on a port. In write mode, two register-address bytes follow, upper byte first. These set an internal pointer. Any further bytes are written to the register file, and the pointer moves on by one after each byte. A random read is a write-mode address phase followed by a repeated start in read mode. A read that starts directly in read mode continues from wherever the pointer was left.

The register file holds a configurable number of bytes, 256 by default. It answers at register addresses from 0 up to its depth. Anywhere else, reads return zero and writes are dropped.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling data line while the clock is high (start) aborts any transfer in progress and begins a device-address phase. A rising data line while the clock is high (stop) returns the slave to idle with the data line released.
- R2: The slave acknowledges the device-address byte only when its upper 7 bits equal `dev_addr`. Bit 0 of that byte selects the direction: 0 for write, 1 for read. On a mismatch the slave leaves the data line released until the next start or stop.
- R3: In write mode, the two bytes after the device address form the 16-bit register address, with the first byte as bits 15:8 and the second as bits 7:0. Each of the two bytes is acknowledged.
- R4: Every write data byte is acknowledged and stored at the current pointer. The pointer then advances by one.
- R5: A write-mode address phase followed by a repeated start in read mode returns the byte at that register address, most significant bit first.
- R6: A read-mode transaction with no address phase returns data starting at the pointer left by the previous transfer.
- R7: After each read byte the pointer advances by one. A master acknowledge makes the slave send the next byte. A master no-acknowledge makes the slave release the data line for the rest of the transaction.
- R8: Register addresses below the register-file depth (0x0000 to 0x00FF by default) are mapped. Reads from any other address return 0x00, and writes to them change no register.
- R9: The slave changes the state of its data-line drive only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Device address the slave responds to |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
A wrong bit counter or state shows up within one byte time. The slave then acknowledges in the wrong bit slot, which the master sees as a missing acknowledge or as a corrupted data bit on the next read. A wrong address pointer is not visible while the write itself happens. It appears only on a later read, as data from a neighbouring register: in the first byte of a current-address read, or in the byte after an incremented burst. For this reason every write in the stimulus is followed, sooner or later, by reads that compare against a model of the register file. A stuck drive after a no-acknowledge or an address mismatch is visible at once, as the data line held low while the master expects it released.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_AHI,
    ST_ACK_AHI,
    ST_ALO,
    ST_ACK_ALO,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_MACK,
    ST_IGNORE
  } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IW = $clog2(DEPTH);

  function automatic logic in_bank(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(DEPTH);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic          wr_hit;
  logic [IW-1:0] wr_idx;

  assign wr_hit = wr_en & in_bank(wr_addr);
  assign wr_idx = wr_addr[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = in_bank(rd_addr) ? mem[rd_addr[IW-1:0]] : '0;

  // R4 / R8: a mapped write is held by the array on the next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/twi_engine.sv
module twi_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr
);
  import twi_pkg::*;

  localparam int CW = $clog2(DATA_W) + 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL     = CW'(DATA_W);

  twi_state_e        st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rx, tx, hi_byte;
  logic [ADDR_W-1:0] ptr;
  logic              rw, m_ack;

  // named internal events
  logic bus_evt, byte_done, dev_done, addr_match, rx_state;
  assign bus_evt    = start_ev | stop_ev;
  assign rx_state   = (st == ST_DEV) | (st == ST_AHI) | (st == ST_ALO) | (st == ST_WDAT);
  assign byte_done  = rx_state & scl_fall & (cnt == FULL) & ~bus_evt;
  assign dev_done   = byte_done & (st == ST_DEV);
  assign addr_match = (rx[DATA_W-1:1] == dev_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      hi_byte <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      m_ack   <= 1'b0;
    end else if (start_ev) begin
      st  <= ST_DEV;
      cnt <= '0;
    end else if (stop_ev) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            rx  <= {rx[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            unique case (st)
              ST_DEV: begin
                if (addr_match) begin
                  rw <= rx[0];
                  st <= ST_ACK_DEV;
                end else begin
                  st <= ST_IGNORE;
                end
              end
              ST_AHI: begin
                hi_byte <= rx;
                st      <= ST_ACK_AHI;
              end
              ST_ALO: begin
                ptr <= {hi_byte, rx};
                st  <= ST_ACK_ALO;
              end
              default: begin
                ptr <= ptr + 1'b1;
                st  <= ST_ACK_WDAT;
              end
            endcase
          end
        end
        ST_ACK_DEV: begin
          if (scl_fall) begin
            if (rw) begin
              st <= ST_RDAT;
              tx <= rd_data;
            end else begin
              st <= ST_AHI;
            end
          end
        end
        ST_ACK_AHI: if (scl_fall) st <= ST_ALO;
        ST_ACK_ALO, ST_ACK_WDAT: if (scl_fall) st <= ST_WDAT;
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              ptr <= ptr + 1'b1;
              st  <= ST_MACK;
            end else begin
              tx  <= {tx[DATA_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          if (scl_fall) begin
            if (m_ack) begin
              st <= ST_RDAT;
              tx <= rd_data;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_ACK_DEV, ST_ACK_AHI, ST_ACK_ALO, ST_ACK_WDAT: sda_oe = 1'b1;
      ST_RDAT: sda_oe = ~tx[DATA_W-1];
      default: sda_oe = 1'b0;
    endcase
  end

  assign wr_en   = byte_done & (st == ST_WDAT);
  assign wr_addr = ptr;
  assign wr_data = rx;
  assign rd_addr = ptr;

  // R1: a start always restarts the address phase from bit 0
  p_start_enters_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_DEV) && (cnt == '0));

  // R1: a stop parks the slave with the line released
  p_stop_idles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (st == ST_IDLE) && !sda_oe);

  // R2: a foreign device address never yields an acknowledge
  p_mismatch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !addr_match) |=> !sda_oe);

  // R4: every stored byte moves the pointer on by one
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + 1'b1);

  // R7: a no-acknowledge from the master releases the line
  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK && scl_fall && !m_ack && !bus_evt) |=> (st == ST_IGNORE) && !sda_oe);

  // R9: drive state moves only while the clock is low
  p_oe_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int RF_DEPTH    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr)
  );

  twi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/twi_reg_slave_tb.sv
module twi_reg_slave_tb;

  localparam logic [6:0] DEV = 7'h36;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  twi_reg_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (DEV),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  model [256];
  logic [15:0] mptr = 16'h0000;

  function automatic logic [7:0] expect_rd(input logic [15:0] a);
    return (a < 16'd256) ? model[a[7:0]] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // R9 monitor: drive may only change while bench clock line is low
  logic prev_oe = 1'b0;
  int   oe_bad  = 0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_bad++;
    prev_oe = sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic tbit(input logic b, output logic r);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    r = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) tbit(b[i], r);
    tbit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tbit(1'b1, r);
      d = {d[6:0], r};
    end
    tbit(nack, r);
  endtask

  // write burst; dev selects target device
  task automatic do_write(input logic [6:0] dev, input logic [15:0] addr,
                          input int n, input logic [7:0] d [4], input string req);
    logic a;
    logic all_ok;
    logic match;
    match  = (dev == DEV);
    all_ok = 1'b1;
    bus_start();
    send_byte({dev, 1'b0}, a);  if (a !== match) all_ok = 1'b0;
    send_byte(addr[15:8], a);   if (a !== match) all_ok = 1'b0;
    send_byte(addr[7:0], a);    if (a !== match) all_ok = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      if (a !== match) all_ok = 1'b0;
      if (match && ((addr + 16'(i)) < 16'd256)) model[8'(addr + 16'(i))] = d[i];
    end
    bus_stop();
    if (match) mptr = addr + 16'(n);
    chk(req, 32'(all_ok), 32'd1, "acknowledge pattern of write");
  endtask

  task automatic read_tail(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      chk(req, 32'(v), 32'(expect_rd(mptr)), $sformatf("read data at %04h", mptr));
      mptr = mptr + 16'd1;
    end
    chk("R7", 32'(sda_oe), 32'd0, "line released after no-acknowledge");
    bus_stop();
  endtask

  task automatic do_rand_read(input logic [15:0] addr, input int n, input string req);
    logic a;
    logic all_ok;
    all_ok = 1'b1;
    bus_start();
    send_byte({DEV, 1'b0}, a); if (!a) all_ok = 1'b0;
    send_byte(addr[15:8], a);  if (!a) all_ok = 1'b0;
    send_byte(addr[7:0], a);   if (!a) all_ok = 1'b0;
    bus_start();
    send_byte({DEV, 1'b1}, a); if (!a) all_ok = 1'b0;
    chk("R3", 32'(all_ok), 32'd1, "address phase acknowledges");
    mptr = addr;
    read_tail(n, req);
  endtask

  task automatic do_cur_read(input int n, input string req);
    logic a;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R2", 32'(a), 32'd1, "read-mode device address acknowledge");
    read_tail(n, req);
  endtask

  initial begin
    logic [7:0] d [4];
    logic [15:0] ad;
    logic r;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", 32'(sda_oe), 32'd0, "released after reset");

    // R3 / R4: single write, high address byte first
    d = '{8'hA5, 8'h00, 8'h00, 8'h00};
    do_write(DEV, 16'h0012, 1, d, "R4");
    do_rand_read(16'h0012, 1, "R3");
    do_rand_read(16'h1200, 1, "R3");

    // R2: foreign device address, then confirm no change and no drive
    d = '{8'h3C, 8'h00, 8'h00, 8'h00};
    do_write(7'h35, 16'h0012, 1, d, "R2");
    do_rand_read(16'h0012, 1, "R2");

    // R4 / R8: burst that runs off the mapped range
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(DEV, 16'h00FE, 4, d, "R4");
    do_rand_read(16'h00FE, 4, "R8");
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    do_write(DEV, 16'h0105, 1, d, "R8");
    do_rand_read(16'h0005, 1, "R8");

    // R6: current-address read continues from pointer
    d = '{8'h01, 8'h02, 8'h03, 8'h04};
    do_write(DEV, 16'h0040, 2, d, "R4");
    do_cur_read(2, "R6");
    do_rand_read(16'h0040, 1, "R5");
    do_cur_read(3, "R6");

    // R1: start in the middle of a byte restarts the address phase
    bus_start();
    tbit(1'b1, r); tbit(1'b0, r); tbit(1'b1, r);
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    do_write(DEV, 16'h0020, 1, d, "R1");
    do_rand_read(16'h0020, 1, "R1");

    // constrained random traffic
    for (int k = 0; k < 22; k++) begin
      int op;
      int n;
      op = int'($urandom % 4);
      n  = 1 + int'($urandom % 4);
      ad = {(($urandom % 5) == 0) ? 8'($urandom) : 8'h00, 8'($urandom)};
      for (int j = 0; j < 4; j++) d[j] = 8'($urandom);
      case (op)
        0, 1: do_write(DEV, ad, n, d, "R4");
        2:    do_rand_read(ad, n, "R5");
        default: do_cur_read(n, "R6");
      endcase
    end

    chk("R9", 32'(oe_bad), 32'd0, "drive changes while clock high");
    summary();
    $finish;
  end

endmodule